// File: doc/BRIEF.md
# Video Shadow Write Decoder

This block sits beside the CPU write path of a system whose video hardware reads its pixels and text from a separate 128 KB slow RAM. Every CPU write is also a candidate for a copy into that slow RAM. The block decides whether a given write must be duplicated. When it must, it produces a one-cycle copy strobe together with the 17-bit slow-RAM address. Each write supplies its bank and offset on the 24-bit CPU bus, along with the physical offset into main RAM that the write lands on.

Eligibility is decided per 1 KB page of a 128 KB window. The window's page index is taken from bits [16:10] of the physical offset, and bit 16 selects the even or the odd 64 KB half. A 6-bit inhibit register masks the text pages and the graphics areas separately. Some graphics areas in the odd half are masked by a combination of two bits. A separate speed register holds one bit that widens copying from the two lowest banks to every RAM bank. Both registers can be written and read back through a small register port.

Top module: `vshadow_decoder`

## Requirements
- R1: After reset the inhibit register reads 8'h08, the speed register reads 8'h00 and `shadow_we` is low.
- R2: Each register reads back the full 8-bit value last written to it. A register that is not written keeps its value.
- R3: Page index 1 of either half (offsets 0x0400–0x07FF) is eligible exactly when inhibit bit 0 is clear.
- R4: Page index 2 of either half (offsets 0x0800–0x0BFF) is eligible exactly when inhibit bit 5 is clear.
- R5: In the even half (physical bit 16 = 0), offsets 0x2000–0x3FFF are eligible when inhibit bit 1 is clear, and offsets 0x4000–0x5FFF when inhibit bit 2 is clear. Offsets 0x6000–0x9FFF are never eligible in the even half.
- R6: In the odd half (physical bit 16 = 1), offsets 0x2000–0x3FFF need inhibit bits 1 and 4 both clear, offsets 0x4000–0x5FFF need bits 2 and 4 both clear, and offsets 0x6000–0x9FFF need bit 3 clear.
- R7: No other 1 KB page of the window is ever eligible.
- R8: While speed bit 4 is clear, only writes with a bank below 2 (CPU address below 0x02_0000) are copied. While it is set, writes to any bank are copied.
- R9: The half and page are taken from physical bits [16:10], and `shadow_addr` equals physical bits [16:0] of the copied write.
- R10: A write sampled with `wr_en` high at a clock edge raises `shadow_we` for exactly the following cycle, if that write is eligible. `shadow_we` is never high unless `wr_en` was high at the previous edge.
- R11: A new inhibit value applies to CPU writes sampled at later edges. A CPU write sampled at the same edge as the register write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_bank | input | 8 | CPU address bank (bits 23:16) |
| wr_off | input | 16 | CPU address offset within the bank |
| wr_phys | input | 23 | Physical main-RAM offset of the write |
| inh_we | input | 1 | Write strobe for the inhibit register |
| spd_we | input | 1 | Write strobe for the speed register |
| reg_wdata | input | 8 | Register write data |
| inh_rdata | output | 8 | Inhibit register readback |
| spd_rdata | output | 8 | Speed register readback |
| shadow_we | output | 1 | One-cycle copy strobe toward slow RAM |
| shadow_addr | output | 17 | Slow-RAM address of the copy |

## Verification
The embedded properties check four things on every cycle: that a strobe never appears without a write at the previous edge, that the copy address follows the physical offset, that the bank gate holds while widening is off, and that no strobe ever comes from a page outside the graphics and text zones or from the even half's upper area. Only the bench scenarios can show the exact truth table of eligibility. The bench sweeps all 64 inhibit codes across all 128 pages and compares each result against an independent range-based model. The bench also covers the speed-bit widening, the same-edge register timing and readback of the unused upper bits.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  localparam int SLOW_AW   = 17;
  localparam int PAGE_LSB  = 10;
  localparam int PAGE_W    = SLOW_AW - PAGE_LSB;
  localparam int NUM_PAGES = 1 << PAGE_W;
  localparam int KB_W      = PAGE_W - 1;
  localparam int INH_W     = 6;

  // Mask bit positions inside the inhibit register
  localparam int IB_TXT1 = 0;
  localparam int IB_HG1  = 1;
  localparam int IB_HG2  = 2;
  localparam int IB_SUP  = 3;
  localparam int IB_AUXG = 4;
  localparam int IB_TXT2 = 5;

  // Eligibility of one 1 KB page: pg[PAGE_W-1] = odd half, low bits = KB within half
  function automatic logic page_ok(input logic [INH_W-1:0] inh,
                                   input logic [PAGE_W-1:0] pg);
    logic       odd;
    logic [KB_W-1:0] kb;
    logic       ok;
    odd = pg[PAGE_W-1];
    kb  = pg[KB_W-1:0];
    ok  = 1'b0;
    if (kb == KB_W'(1))                              ok = ~inh[IB_TXT1];
    else if (kb == KB_W'(2))                         ok = ~inh[IB_TXT2];
    else if (kb >= KB_W'(8)  && kb < KB_W'(16))      ok = ~(inh[IB_HG1] | (odd & inh[IB_AUXG]));
    else if (kb >= KB_W'(16) && kb < KB_W'(24))      ok = ~(inh[IB_HG2] | (odd & inh[IB_AUXG]));
    else if (kb >= KB_W'(24) && kb < KB_W'(40))      ok = odd & ~inh[IB_SUP];
    return ok;
  endfunction
endpackage

// File: rtl/vsd_ctrl_regs.sv
module vsd_ctrl_regs #(
  parameter int          RW      = 8,
  parameter logic [7:0]  INH_RST = 8'h08,
  parameter logic [7:0]  SPD_RST = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inh_we,
  input  logic          spd_we,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] inh_q,
  output logic [RW-1:0] spd_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inh_q <= RW'(INH_RST);
      spd_q <= RW'(SPD_RST);
    end else begin
      if (inh_we) inh_q <= wdata;
      if (spd_we) spd_q <= wdata;
    end
  end

  AST_INH_RESET: assert property (@(posedge clk) !rst_n |=> inh_q == RW'(INH_RST)); // R1
  AST_SPD_RESET: assert property (@(posedge clk) !rst_n |=> spd_q == RW'(SPD_RST)); // R1
  AST_INH_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    inh_we |=> inh_q == $past(wdata)); // R2
  AST_SPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !spd_we |=> $stable(spd_q)); // R2
endmodule

// File: rtl/vsd_zone_map.sv
module vsd_zone_map
  import vsd_pkg::*;
(
  input  logic [INH_W-1:0]     inh,
  output logic [NUM_PAGES-1:0] page_flags
);
  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    assign page_flags[p] = page_ok(inh, PAGE_W'(p));
  end
endmodule

// File: rtl/vsd_shadow_stage.sv
module vsd_shadow_stage
  import vsd_pkg::*;
#(
  parameter int PHYS_W    = 23,
  parameter int BANK_W    = 8,
  parameter int LOW_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [BANK_W-1:0]    wr_bank,
  input  logic [PHYS_W-1:0]    wr_phys,
  input  logic [NUM_PAGES-1:0] page_flags,
  input  logic                 all_banks,
  output logic                 shadow_we,
  output logic [SLOW_AW-1:0]   shadow_addr
);
  // Named internal events for the checks below
  logic [PAGE_W-1:0] page_idx;
  logic              page_hit;
  logic              bank_low;
  logic              fire;
  logic              half_bit;
  logic [KB_W-1:0]   kb_idx;

  assign page_idx = wr_phys[SLOW_AW-1:PAGE_LSB];
  assign half_bit = wr_phys[SLOW_AW-1];
  assign kb_idx   = wr_phys[SLOW_AW-2:PAGE_LSB];
  assign page_hit = page_flags[page_idx];
  assign bank_low = (wr_bank < BANK_W'(LOW_BANKS));
  assign fire     = wr_en & page_hit & (all_banks | bank_low);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_we   <= 1'b0;
      shadow_addr <= '0;
    end else begin
      shadow_we <= fire;
      if (wr_en) shadow_addr <= wr_phys[SLOW_AW-1:0];
    end
  end

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_we |-> $past(wr_en)); // R10
  AST_COPY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_we |-> shadow_addr == $past(wr_phys[SLOW_AW-1:0])); // R9
  AST_BANK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_we && !$past(all_banks)) |-> ($past(wr_bank) < BANK_W'(LOW_BANKS))); // R8
  AST_EVEN_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_we && !$past(half_bit)) |-> ($past(kb_idx) < KB_W'(24))); // R5
  AST_ZONES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_we |-> ($past(kb_idx) == KB_W'(1) || $past(kb_idx) == KB_W'(2) ||
                   ($past(kb_idx) >= KB_W'(8) && $past(kb_idx) < KB_W'(40)))); // R7
endmodule

// File: rtl/vshadow_decoder.sv
module vshadow_decoder
  import vsd_pkg::*;
#(
  parameter int PHYS_W        = 23,
  parameter int BANK_W        = 8,
  parameter int OFF_W         = 16,
  parameter int RW            = 8,
  parameter int LOW_BANKS     = 2,
  parameter int SPD_ALL_BIT   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [BANK_W-1:0]  wr_bank,
  input  logic [OFF_W-1:0]   wr_off,
  input  logic [PHYS_W-1:0]  wr_phys,
  input  logic               inh_we,
  input  logic               spd_we,
  input  logic [RW-1:0]      reg_wdata,
  output logic [RW-1:0]      inh_rdata,
  output logic [RW-1:0]      spd_rdata,
  output logic               shadow_we,
  output logic [SLOW_AW-1:0] shadow_addr
);
  logic [NUM_PAGES-1:0] page_flags;
  logic                 all_banks;
  logic                 off_unused;

  // Offset only matters through the bank comparison (bank < LOW_BANKS covers the low window)
  assign off_unused = ^wr_off;

  vsd_ctrl_regs #(.RW(RW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .inh_we (inh_we),
    .spd_we (spd_we),
    .wdata  (reg_wdata),
    .inh_q  (inh_rdata),
    .spd_q  (spd_rdata)
  );

  assign all_banks = spd_rdata[SPD_ALL_BIT];

  vsd_zone_map u_map (
    .inh        (inh_rdata[INH_W-1:0]),
    .page_flags (page_flags)
  );

  vsd_shadow_stage #(
    .PHYS_W    (PHYS_W),
    .BANK_W    (BANK_W),
    .LOW_BANKS (LOW_BANKS)
  ) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_bank     (wr_bank),
    .wr_phys     (wr_phys),
    .page_flags  (page_flags),
    .all_banks   (all_banks),
    .shadow_we   (shadow_we),
    .shadow_addr (shadow_addr)
  );

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !shadow_we); // R10
endmodule

// File: tb/vshadow_decoder_bench.sv
module vshadow_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_bank = '0;
  logic [15:0] wr_off = '0;
  logic [22:0] wr_phys = '0;
  logic        inh_we = 1'b0;
  logic        spd_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  inh_rdata, spd_rdata;
  logic        shadow_we;
  logic [16:0] shadow_addr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vshadow_decoder u_vshadow_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_off(wr_off),
    .wr_phys(wr_phys), .inh_we(inh_we), .spd_we(spd_we), .reg_wdata(reg_wdata),
    .inh_rdata(inh_rdata), .spd_rdata(spd_rdata), .shadow_we(shadow_we),
    .shadow_addr(shadow_addr)
  );

  // Independent model: byte-offset ranges within a 64 KB half
  function automatic bit model_ok(input logic [5:0] m, input bit odd, input int off);
    if (off >= 'h0400 && off < 'h0800) return !m[0];
    if (off >= 'h0800 && off < 'h0C00) return !m[5];
    if (off >= 'h2000 && off < 'h4000) return odd ? !(m[1] || m[4]) : !m[1];
    if (off >= 'h4000 && off < 'h6000) return odd ? !(m[2] || m[4]) : !m[2];
    if (off >= 'h6000 && off < 'hA000) return odd && !m[3];
    return 1'b0;
  endfunction

  function automatic string tag_for(input bit odd, input int off);
    if (off >= 'h0400 && off < 'h0800) return "R3";
    if (off >= 'h0800 && off < 'h0C00) return "R4";
    if (off >= 'h2000 && off < 'hA000) return odd ? "R6" : "R5";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input bit spd, input logic [7:0] v);
    @(negedge clk);
    reg_wdata = v; inh_we = !spd; spd_we = spd;
    @(negedge clk);
    inh_we = 1'b0; spd_we = 1'b0;
  endtask

  // One CPU write; result visible the cycle after the sampling edge
  task automatic cpu_write(input string req, input logic [7:0] bank, input logic [15:0] off,
                           input logic [22:0] phys, input bit exp_we);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = bank; wr_off = off; wr_phys = phys;
    @(negedge clk);
    wr_en = 1'b0;
    check(req, {15'd0, shadow_we, exp_we ? shadow_addr : 17'd0},
               {15'd0, exp_we, exp_we ? phys[16:0] : 17'd0});
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 inhibit reset", inh_rdata, 8'h08);
    check("R1 speed reset", spd_rdata, 8'h00);
    check("R1 strobe reset", shadow_we, 1'b0);

    // Reset value 0x08: odd-half upper graphics blocked, text page 1 open
    cpu_write("R6", 8'h01, 16'h7000, {6'h2A, 1'b1, 6'd28, 10'h0F0}, 1'b0);
    cpu_write("R3", 8'h00, 16'h0400, {6'h01, 1'b0, 6'd1, 10'h3FF}, 1'b1);

    // Exhaustive sweep: all inhibit codes x all pages of the window
    for (int m = 0; m < 64; m++) begin
      logic [7:0] v;
      v = {m[0], ~m[1], m[5:0]};
      reg_write(1'b0, v);
      check("R2 inhibit readback", inh_rdata, v);
      for (int pg = 0; pg < 128; pg++) begin
        bit odd;
        int off;
        logic [22:0] phys;
        odd  = pg[6];
        off  = (pg % 64) * 1024;
        phys = {m[5:0] ^ 6'h15, pg[6:0], 10'(pg * 7 + m)};
        cpu_write(tag_for(odd, off), {7'd0, odd}, 16'(off + 3), phys,
                  model_ok(m[5:0], odd, off));
      end
    end

    // Bank gate
    reg_write(1'b0, 8'h00);
    cpu_write("R8 high bank blocked", 8'h05, 16'h0400, {6'h05, 1'b0, 6'd1, 10'h001}, 1'b0);
    cpu_write("R8 bank 2 blocked", 8'h02, 16'h2000, {6'h02, 1'b0, 6'd8, 10'h000}, 1'b0);
    cpu_write("R8 bank 1 allowed", 8'h01, 16'hFFFF, {6'h00, 1'b1, 6'd39, 10'h3FF}, 1'b1);
    reg_write(1'b1, 8'h10);
    check("R2 speed readback", spd_rdata, 8'h10);
    cpu_write("R8 widened", 8'h05, 16'h0400, {6'h05, 1'b0, 6'd1, 10'h001}, 1'b1);
    cpu_write("R8 widened top", 8'hE7, 16'h6000, {6'h3F, 1'b1, 6'd24, 10'h2AA}, 1'b1);
    cpu_write("R9 even upper zone", 8'h40, 16'h6000, {6'h3F, 1'b0, 6'd24, 10'h2AA}, 1'b0);
    reg_write(1'b1, 8'hEF);
    check("R2 speed readback", spd_rdata, 8'hEF);
    cpu_write("R8 bit4 clear", 8'h05, 16'h0400, {6'h05, 1'b0, 6'd1, 10'h001}, 1'b0);
    reg_write(1'b0, 8'h3F);
    check("R2 speed unaffected", spd_rdata, 8'hEF);

    // Same-edge register write uses old value
    reg_write(1'b0, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 8'h00; wr_off = 16'h0500; wr_phys = {6'h00, 1'b0, 6'd1, 10'h100};
    inh_we = 1'b1; reg_wdata = 8'h01;
    @(negedge clk);
    inh_we = 1'b0;
    wr_phys = {6'h00, 1'b1, 6'd1, 10'h101}; wr_bank = 8'h01;
    check("R11 old value used", shadow_we, 1'b1);
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 new value applied", shadow_we, 1'b0);
    @(negedge clk);
    check("R10 one-cycle strobe", shadow_we, 1'b0);

    // Strobe width
    cpu_write("R10 strobe", 8'h00, 16'h2000, {6'h00, 1'b0, 6'd9, 10'h005}, 1'b1);
    @(negedge clk);
    check("R10 strobe drops", shadow_we, 1'b0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule